// File: doc/BRIEF.md
# Type-B Start-of-Frame and Character Decoder

This block sits behind a subcarrier correlator in a proximity-card receive path. The correlator delivers one signed soft-decision value per half bit period, so there are two samples per elementary time unit (ETU). A positive value stands for logic 1. Zero and negative values stand for logic 0. The block looks for a start-of-frame made of a long low phase followed by a short high phase. It then frames asynchronous characters until a terminating all-zero character or a timing fault.

Every timing limit is counted in samples. The accepted windows are wider than the nominal line timing, because the correlator spreads edges. A sample that breaks any window drops the block back to the unsynchronized state and clears the start-of-frame flag. Each character has a 0 start bit, eight data bits sent least-significant first, and a 1 stop bit. A data bit is decided from the sum of the two samples in its ETU.

Top module: `bsof_char_decoder`

## Requirements
- R1: While `rst_n` is low, `byte_vld`, `eof_seen` and `sof_seen` are 0. An asynchronous reset during a frame clears `sof_seen` at once.
- R2: A sample is logic 1 only when `smp` is greater than zero. A value of 0 counts as logic 0. Cycles with `smp_vld` low have no effect on state or outputs.
- R3: A run of 16 to 28 logic-0 samples, followed by a logic-1 sample, is accepted as the low phase. `sof_seen` rises one clock after that logic-1 sample.
- R4: A low phase that ends after fewer than 16 samples is rejected, and `sof_seen` stays 0.
- R5: A low phase whose 29th consecutive logic-0 sample arrives is rejected, and `sof_seen` stays 0.
- R6: After an accepted low phase, 1 to 4 logic-1 samples may precede the first start bit. A 5th logic-1 sample desynchronizes the block and clears `sof_seen`.
- R7: A character is 20 samples: a start bit, eight data bits with bit 0 first, and a stop bit, two samples each. Each bit is 1 when the sum of its two samples is greater than zero.
- R8: After a character whose stop bit decides 1, `byte_vld` is high for exactly one clock, one clock after the last stop-bit sample. `byte_data` holds the character and stays at that value until the next character's data arrives.
- R9: Between characters, up to 52 logic-1 samples may precede the next start bit. The 53rd logic-1 sample desynchronizes the block and clears `sof_seen`.
- R10: A character whose data bits and stop bit all decide 0 is the end of frame. `eof_seen` pulses for one clock, `sof_seen` clears in the same clock, and `byte_vld` stays low.
- R11: A stop bit that decides 0 after a non-zero byte desynchronizes the block. It clears `sof_seen` and gives neither `byte_vld` nor `eof_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Marks a new soft-decision sample |
| smp | input | SMP_W | Signed soft-decision sample |
| byte_vld | output | 1 | One-clock strobe for a correctly framed character |
| byte_data | output | DATA_W | Character received most recently |
| sof_seen | output | 1 | High from an accepted start-of-frame until the block desynchronizes or the frame ends |
| eof_seen | output | 1 | One-clock strobe for the end-of-frame character |

## Verification
A wrong phase state or an off-by-one sample counter shows first on `sof_seen`. The flag rises or falls one sample too early or too late around a window edge, so the bench drives every window at its last legal count and one count past it, and checks the flag three clocks later. A slip in the ETU position counter inside a character shifts the data one bit or misreads the stop bit. That shows within the same 20-sample character as a wrong `byte_data` or a missing `byte_vld`. Samples whose pair sums sit at zero expose a wrong soft-decision threshold in one byte.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  // Receive phases of the decoder
  typedef enum logic [2:0] {
    ST_UNSYNC = 3'd0,  // hunting for a low run
    ST_LOW    = 3'd1,  // counting start-of-frame low phase
    ST_HIGH   = 3'd2,  // high phase before first start bit
    ST_CHAR   = 3'd3,  // inside a character
    ST_GAP    = 3'd4   // idle ones between characters
  } bsd_state_e;

  localparam int SMP_PER_ETU = 2;

endpackage

// File: rtl/bsd_pair_slicer.sv
// Holds the first sample of an ETU and decides the bit from the pair sum.
module bsd_pair_slicer #(
  parameter int SMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold_en,
  input  logic signed [SMP_W-1:0] smp,
  output logic                    pair_one
);

  logic signed [SMP_W-1:0] held_q;
  logic signed [SMP_W:0]   pair_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (hold_en) begin
      held_q <= smp;
    end
  end

  assign pair_sum = {held_q[SMP_W-1], held_q} + {smp[SMP_W-1], smp};
  assign pair_one = !pair_sum[SMP_W] && (pair_sum != '0);

endmodule

// File: rtl/bsd_bit_shift.sv
// Assembles a character, least-significant bit arriving first.
module bsd_bit_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) begin
      sh_d = {bit_in, sh_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (shift_en) begin
      sh_q <= sh_d;
    end
  end

  assign data_o = sh_q;

endmodule

// File: rtl/bsd_frame_fsm.sv
// Phase tracking, timing windows and character positions.
module bsd_frame_fsm
  import bsd_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int LOW_MIN_ETU  = 8,
  parameter int LOW_MAX_ETU  = 14,
  parameter int HIGH_MAX_ETU = 2,
  parameter int GAP_MAX_ETU  = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic smp_is_one,
  input  logic pair_one,
  input  logic byte_is_zero,
  output logic hold_en,
  output logic shift_en,
  output logic byte_vld,
  output logic sof_seen,
  output logic eof_seen
);

  localparam int LOW_MIN  = LOW_MIN_ETU  * SMP_PER_ETU;
  localparam int LOW_MAX  = LOW_MAX_ETU  * SMP_PER_ETU;
  localparam int HIGH_MAX = HIGH_MAX_ETU * SMP_PER_ETU;
  localparam int GAP_MAX  = GAP_MAX_ETU  * SMP_PER_ETU;
  localparam int LIM_A    = (LOW_MAX > HIGH_MAX) ? LOW_MAX : HIGH_MAX;
  localparam int LIM_TOP  = (LIM_A > GAP_MAX) ? LIM_A : GAP_MAX;
  localparam int CNT_W    = $clog2(LIM_TOP + 2);
  localparam int CHAR_SMP = (DATA_W + 2) * SMP_PER_ETU;
  localparam int POS_W    = $clog2(CHAR_SMP + 1);

  localparam logic [CNT_W-1:0] LOW_MIN_C  = CNT_W'(LOW_MIN);
  localparam logic [CNT_W-1:0] LOW_MAX_C  = CNT_W'(LOW_MAX);
  localparam logic [CNT_W-1:0] HIGH_MAX_C = CNT_W'(HIGH_MAX);
  localparam logic [CNT_W-1:0] GAP_MAX_C  = CNT_W'(GAP_MAX);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
  localparam logic [POS_W-1:0] POS_ONE    = POS_W'(1);
  localparam logic [POS_W-1:0] POS_LAST   = POS_W'(CHAR_SMP - 1);

  bsd_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, idle_lim;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             sof_q, sof_d;
  logic             bvld_q, bvld_d;
  logic             eof_q, eof_d;

  assign cnt_inc  = cnt_q + CNT_ONE;
  assign idle_lim = (st_q == ST_GAP) ? GAP_MAX_C : HIGH_MAX_C;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    pos_d    = pos_q;
    sof_d    = sof_q;
    bvld_d   = 1'b0;
    eof_d    = 1'b0;
    hold_en  = 1'b0;
    shift_en = 1'b0;
    if (smp_vld) begin
      case (st_q)
        ST_UNSYNC: begin
          if (!smp_is_one) begin
            st_d  = ST_LOW;
            cnt_d = CNT_ONE;
          end
        end
        ST_LOW: begin
          if (!smp_is_one) begin
            if (cnt_inc > LOW_MAX_C) begin
              st_d  = ST_UNSYNC;
              sof_d = 1'b0;
            end else begin
              cnt_d = cnt_inc;
            end
          end else if (cnt_q < LOW_MIN_C) begin
            st_d  = ST_UNSYNC;
            sof_d = 1'b0;
          end else begin
            st_d  = ST_HIGH;
            cnt_d = CNT_ONE;
            sof_d = 1'b1;
          end
        end
        ST_HIGH, ST_GAP: begin
          if (smp_is_one) begin
            if (cnt_inc > idle_lim) begin
              st_d  = ST_UNSYNC;
              sof_d = 1'b0;
            end else begin
              cnt_d = cnt_inc;
            end
          end else begin
            st_d  = ST_CHAR;
            pos_d = POS_ONE;
          end
        end
        ST_CHAR: begin
          pos_d = pos_q + POS_ONE;
          if (pos_q == POS_LAST) begin
            if (pair_one) begin
              bvld_d = 1'b1;
              st_d   = ST_GAP;
              cnt_d  = '0;
            end else begin
              eof_d  = byte_is_zero;
              st_d   = ST_UNSYNC;
              sof_d  = 1'b0;
            end
          end else if (!pos_q[0]) begin
            hold_en = 1'b1;
          end else if (pos_q != POS_ONE) begin
            shift_en = 1'b1;
          end
        end
        default: begin
          st_d  = ST_UNSYNC;
          sof_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_UNSYNC;
      cnt_q  <= '0;
      pos_q  <= '0;
      sof_q  <= 1'b0;
      bvld_q <= 1'b0;
      eof_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pos_q  <= pos_d;
      sof_q  <= sof_d;
      bvld_q <= bvld_d;
      eof_q  <= eof_d;
    end
  end

  assign byte_vld = bvld_q;
  assign sof_seen = sof_q;
  assign eof_seen = eof_q;

endmodule

// File: rtl/bsof_char_decoder.sv
module bsof_char_decoder #(
  parameter int SMP_W        = 8,
  parameter int DATA_W       = 8,
  parameter int LOW_MIN_ETU  = 8,
  parameter int LOW_MAX_ETU  = 14,
  parameter int HIGH_MAX_ETU = 2,
  parameter int GAP_MAX_ETU  = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp,
  output logic                    byte_vld,
  output logic [DATA_W-1:0]       byte_data,
  output logic                    sof_seen,
  output logic                    eof_seen
);

  logic smp_is_one;
  logic pair_one;
  logic hold_en;
  logic shift_en;
  logic byte_is_zero;

  assign smp_is_one   = !smp[SMP_W-1] && (smp != '0);
  assign byte_is_zero = (byte_data == '0);

  bsd_pair_slicer #(.SMP_W(SMP_W)) u_slicer (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_en  (hold_en),
    .smp      (smp),
    .pair_one (pair_one)
  );

  bsd_bit_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .bit_in   (pair_one),
    .data_o   (byte_data)
  );

  bsd_frame_fsm #(
    .DATA_W       (DATA_W),
    .LOW_MIN_ETU  (LOW_MIN_ETU),
    .LOW_MAX_ETU  (LOW_MAX_ETU),
    .HIGH_MAX_ETU (HIGH_MAX_ETU),
    .GAP_MAX_ETU  (GAP_MAX_ETU)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_vld      (smp_vld),
    .smp_is_one   (smp_is_one),
    .pair_one     (pair_one),
    .byte_is_zero (byte_is_zero),
    .hold_en      (hold_en),
    .shift_en     (shift_en),
    .byte_vld     (byte_vld),
    .sof_seen     (sof_seen),
    .eof_seen     (eof_seen)
  );

endmodule

// File: rtl/bsof_char_decoder_chk.sv
module bsof_char_decoder_chk #(
  parameter int SMP_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_vld,
  input logic signed [SMP_W-1:0] smp,
  input logic                    byte_vld,
  input logic                    sof_seen,
  input logic                    eof_seen
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!byte_vld && !eof_seen && !sof_seen));

  p_idle_no_effect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ($stable(sof_seen) && !byte_vld && !eof_seen));

  p_sof_on_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sof_seen) |-> ($past(smp_vld) && ($past(smp) > 0)));

  p_byte_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  p_byte_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> sof_seen);

  p_eof_ends_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eof_seen |-> (!sof_seen && !byte_vld && $past(sof_seen)));

endmodule

bind bsof_char_decoder bsof_char_decoder_chk #(.SMP_W(SMP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_vld  (smp_vld),
  .smp      (smp),
  .byte_vld (byte_vld),
  .sof_seen (sof_seen),
  .eof_seen (eof_seen)
);

// File: tb/bsof_char_decoder_test.sv
`timescale 1ns/1ps
module bsof_char_decoder_test;

  logic              clk;
  logic              rst_n;
  logic              smp_vld;
  logic signed [7:0] smp;
  logic              byte_vld;
  logic [7:0]        byte_data;
  logic              sof_seen;
  logic              eof_seen;

  int  n_chk;
  int  n_err;
  int  nbytes;
  int  neofs;
  logic [7:0] last_byte;
  bit  stretch;
  bit  done;

  bsof_char_decoder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp       (smp),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .sof_seen  (sof_seen),
    .eof_seen  (eof_seen)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Fields: [31:24] low samples, [23:16] high samples, [15:8] byte, [7:0] accepted
  localparam logic [31:0] VEC [8] = '{
    {8'd20, 8'd2, 8'hA5, 8'd1},
    {8'd16, 8'd2, 8'h3C, 8'd1},
    {8'd15, 8'd2, 8'h11, 8'd0},
    {8'd28, 8'd4, 8'h81, 8'd1},
    {8'd29, 8'd2, 8'h22, 8'd0},
    {8'd20, 8'd5, 8'h33, 8'd0},
    {8'd20, 8'd1, 8'hFF, 8'd1},
    {8'd24, 8'd3, 8'h00, 8'd1}
  };

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld) begin
        last_byte = byte_data;
        nbytes++;
      end
      if (eof_seen) neofs++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drv(input int v);
    if (stretch) begin
      @(negedge clk);
      smp_vld = 1'b0;
      smp     = -8'sd77;
    end
    @(negedge clk);
    smp_vld = 1'b1;
    smp     = 8'(v);
  endtask

  task automatic put_bit(input bit b);
    drv(b ? 20 : -20);
    drv(b ? 20 : -20);
  endtask

  task automatic put_char(input logic [7:0] b, input bit stop);
    put_bit(1'b0);
    for (int j = 0; j < 8; j++) put_bit(b[j]);
    put_bit(stop);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      smp_vld = 1'b0;
    end
  endtask

  task automatic sof(input int lo, input int hi);
    repeat (lo) drv(-20);
    repeat (hi) drv(20);
  endtask

  task automatic wrap_up;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    wrap_up();
  end

  initial begin
    int nb0;
    int ne0;
    n_chk = 0; n_err = 0; nbytes = 0; neofs = 0; stretch = 1'b0; done = 1'b0;
    last_byte = '0;
    rst_n = 1'b0; smp_vld = 1'b0; smp = '0;
    repeat (3) @(negedge clk);
    chk("R1 byte_vld in reset", byte_vld, 0);
    chk("R1 sof_seen in reset", sof_seen, 0);
    chk("R1 eof_seen in reset", eof_seen, 0);
    rst_n = 1'b1;
    idle(2);

    // Table of start-of-frame windows
    for (int i = 0; i < 8; i++) begin
      int lo, hi, ok;
      logic [7:0] bt;
      string tag;
      lo = int'(VEC[i][31:24]);
      hi = int'(VEC[i][23:16]);
      bt = VEC[i][15:8];
      ok = int'(VEC[i][7:0]);
      tag = ok != 0 ? "R3" : (lo < 16 ? "R4" : (lo > 28 ? "R5" : "R6"));
      nb0 = nbytes; ne0 = neofs;
      sof(lo, hi);
      idle(3);
      chk($sformatf("%s sof_seen after window lo=%0d hi=%0d", tag, lo, hi), sof_seen, ok);
      if (ok != 0) begin
        put_char(bt, 1'b1);
        put_char(8'h00, 1'b0);
        idle(3);
        chk("R7 byte count", nbytes - nb0, 1);
        chk("R7 byte value", last_byte, bt);
        chk("R10 eof pulse count", neofs - ne0, 1);
        chk("R10 sof cleared at eof", sof_seen, 0);
      end else begin
        repeat (30) drv(20);
        idle(3);
        chk({tag, " no byte after rejected window"}, nbytes - nb0, 0);
        chk({tag, " no eof after rejected window"}, neofs - ne0, 0);
      end
      repeat (6) drv(20);
    end

    // R2 R7 R8: soft pair sums, zero-valued low samples, gaps in the strobe
    stretch = 1'b1;
    nb0 = nbytes;
    repeat (20) drv(0);
    drv(1); drv(1);
    idle(3);
    chk("R2 zero samples form low phase", sof_seen, 1);
    put_bit(1'b0);
    drv(30);  drv(-10);
    drv(5);   drv(-5);
    drv(-30); drv(10);
    drv(0);   drv(1);
    for (int j = 0; j < 4; j++) put_bit(1'b0);
    drv(20);
    drv(20);
    @(negedge clk);
    smp_vld = 1'b0;
    chk("R8 byte_vld one clock after stop", byte_vld, 1);
    chk("R7 soft pair decisions", byte_data, 8'h09);
    @(negedge clk);
    chk("R8 byte_vld falls after one clock", byte_vld, 0);
    idle(5);
    chk("R8 byte_data held", byte_data, 8'h09);
    chk("R2 strobe-low cycles ignored", nbytes - nb0, 1);
    put_char(8'h00, 1'b0);
    idle(3);
    stretch = 1'b0;

    // R9: inter-character gap at limit and one past it
    nb0 = nbytes; ne0 = neofs;
    sof(20, 2);
    put_char(8'h12, 1'b1);
    repeat (52) drv(20);
    put_char(8'h34, 1'b1);
    put_char(8'h00, 1'b0);
    idle(3);
    chk("R9 two bytes across 52-sample gap", nbytes - nb0, 2);
    chk("R9 second byte value", last_byte, 8'h34);
    chk("R10 eof after two bytes", neofs - ne0, 1);
    sof(20, 2);
    put_char(8'h56, 1'b1);
    repeat (53) drv(20);
    idle(3);
    chk("R9 sof cleared after 53-sample gap", sof_seen, 0);
    repeat (10) drv(20);

    // R11: stop error on non-zero byte
    nb0 = nbytes; ne0 = neofs;
    sof(20, 2);
    put_char(8'h5A, 1'b0);
    idle(3);
    chk("R11 no byte on stop error", nbytes - nb0, 0);
    chk("R11 no eof on stop error", neofs - ne0, 0);
    chk("R11 sof cleared on stop error", sof_seen, 0);
    repeat (10) drv(20);

    // R1: reset during a frame
    sof(20, 1);
    idle(3);
    chk("R1 sof set before mid-frame reset", sof_seen, 1);
    rst_n = 1'b0;
    #1;
    chk("R1 sof cleared by async reset", sof_seen, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    chk("R1 sof stays low after reset", sof_seen, 0);

    wrap_up();
  end

endmodule